// File: doc/BRIEF.md
# Reset cause recorder with software one-shot resets

This block keeps a sticky record of which sources have reset the system since software last looked. Request pulses from the external reset pin, the watchdog, the brown-out detector and the core's system-reset request each set their own flag. The flags are held in the power-on domain, so the chip or CPU resets they describe do not clear them. Only a true power-on clears them, and that power-on then leaves its own flag set. Software clears a flag by writing 1 to it.

The same register bus also reaches a small control register with two self-clearing bits. One starts a chip-wide reset pulse and the other starts a CPU-only reset pulse. Each pulse lasts a fixed number of clock cycles, two by default, and then the bit clears itself. Both bits are guarded by the write-protection gate from the unlock controller. The chip pulse marks the power-on flag, the same as a real power-on would, and the CPU pulse marks the CPU flag. The logic that fans these requests out to the rest of the chip lies outside this block.

Top module: `rst_cause_ctrl`

## Requirements
- R1: After the power-on reset (rst_ni low) the status register reads 0x01, with only the power-on flag at bit 0 set. The control register reads 0x00, and chip_rst_o and cpu_rst_o are low.
- R2: A status write (reg_sel_i = 0) clears every flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R3: A request input that is high at a clock edge sets its flag at that edge. The positions are: pin at bit 1, watchdog at bit 2, brown-out at bit 4, core system-reset request at bit 5.
- R4: When several request inputs are high at the same edge, all of their flags are set.
- R5: When a flag's set event and a write-1 clear of that flag fall on the same edge, the flag ends up 1.
- R6: A control write (reg_sel_i = 1) made while unlock_i is low is ignored. No pulse starts and the control register keeps reading 0.
- R7: An unlocked control write with bit 0 set drives chip_rst_o high for exactly 2 cycles, starting with the cycle after the write edge. Control bit 0 reads 1 during those cycles and 0 afterwards.
- R8: The chip pulse sets the power-on flag at bit 0 and leaves all other flags unchanged.
- R9: An unlocked control write with bit 1 set drives cpu_rst_o high for exactly 2 cycles and sets the CPU flag at bit 7. chip_rst_o stays low.
- R10: Unused positions always read 0, and writing to them has no effect. These are status bits 3 and 6 and control bits 7..2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| pin_req_i | input | 1 | Reset request from the external reset pin |
| wdt_req_i | input | 1 | Reset request from the watchdog |
| bod_req_i | input | 1 | Reset request from brown-out detection |
| sys_req_i | input | 1 | System-reset request from the core |
| unlock_i | input | 1 | High while write protection is disabled |
| wr_en_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the status register, 1 selects the control register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register (combinational) |
| chip_rst_o | output | 1 | Chip-wide reset request pulse |
| cpu_rst_o | output | 1 | CPU-only reset request pulse |

## Verification
The bench drives inputs on falling edges and samples on falling edges. A flag set by a request input, or cleared by a status write, can therefore be read on the first falling edge after the rising edge that captured it. A control write raises its pulse output by that same falling edge. The bench samples it there and on the next falling edge, and expects it low on the third. The flag set by a pulse is due one edge later than the pulse, so the bench reads it only after the pulse has ended.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int unsigned FLAG_W   = 8;
  localparam int unsigned CTRL_N   = 2;
  localparam int unsigned B_POR    = 0;
  localparam int unsigned B_PIN    = 1;
  localparam int unsigned B_WDT    = 2;
  localparam int unsigned B_BOD    = 4;
  localparam int unsigned B_SYS    = 5;
  localparam int unsigned B_CPU    = 7;
  localparam int unsigned C_CHIP   = 0;
  localparam int unsigned C_CPU    = 1;
  localparam logic [FLAG_W-1:0] FLAG_MASK =
    FLAG_W'((1 << B_POR) | (1 << B_PIN) | (1 << B_WDT) |
            (1 << B_BOD) | (1 << B_SYS) | (1 << B_CPU));
  localparam logic [FLAG_W-1:0] FLAG_RST = FLAG_W'(1 << B_POR);
endpackage

// File: rtl/rst_flag_reg.sv
module rst_flag_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] MASK = '1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;
  logic unused_bits;
  assign unused_bits = ^((set_i | clr_i) & ~MASK);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       flag_q[i] <= RST_VAL[i];
        else if (set_i[i]) flag_q[i] <= 1'b1;
        else if (clr_i[i]) flag_q[i] <= 1'b0;
      end

      a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[i] |=> flag_q[i]);
      a_r2_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[i] && !set_i[i]) |=> !flag_q[i]);
    end else begin : g_tie
      assign flag_q[i] = 1'b0;
    end
  end

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i | clr_i) == '0) |=> $stable(flag_q));

  assign flag_o = flag_q;
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int unsigned CYC = 2,
  localparam int unsigned CNT_W = $clog2(CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic pulse_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= CNT_W'(CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);

  a_r7_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> pulse_o);
  a_r7_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == CNT_W'(1)) |=> !pulse_o);
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_req_i,
  input  logic              wdt_req_i,
  input  logic              bod_req_i,
  input  logic              sys_req_i,
  input  logic              unlock_i,
  input  logic              wr_en_i,
  input  logic              reg_sel_i,
  input  logic [FLAG_W-1:0] wdata_i,
  output logic [FLAG_W-1:0] rdata_o,
  output logic              chip_rst_o,
  output logic              cpu_rst_o
);
  logic [CTRL_N-1:0] ctrl_q;
  logic [FLAG_W-1:0] set_vec, clr_vec, flags;

  for (genvar c = 0; c < CTRL_N; c++) begin : g_pulse
    rst_pulse_gen #(.CYC(PULSE_CYC)) u_pg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (wr_en_i & reg_sel_i & unlock_i & wdata_i[c]),
      .pulse_o(ctrl_q[c])
    );
  end

  assign chip_rst_o = ctrl_q[C_CHIP];
  assign cpu_rst_o  = ctrl_q[C_CPU];

  always_comb begin
    set_vec        = '0;
    set_vec[B_POR] = chip_rst_o;
    set_vec[B_PIN] = pin_req_i;
    set_vec[B_WDT] = wdt_req_i;
    set_vec[B_BOD] = bod_req_i;
    set_vec[B_SYS] = sys_req_i;
    set_vec[B_CPU] = cpu_rst_o;
  end

  assign clr_vec = (wr_en_i && !reg_sel_i) ? wdata_i : '0;

  // held in the power-on domain only; the pulses above never reach rst_ni
  rst_flag_reg #(.W(FLAG_W), .MASK(FLAG_MASK), .RST_VAL(FLAG_RST)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .flag_o(flags)
  );

  assign rdata_o = reg_sel_i ? {{(FLAG_W-CTRL_N){1'b0}}, ctrl_q} : flags;

  a_r6_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && reg_sel_i && !unlock_i && !chip_rst_o && !cpu_rst_o)
      |=> (!chip_rst_o && !cpu_rst_o));
  a_r8_chip_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_o |=> flags[B_POR]);
  a_r9_cpu_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_o |=> flags[B_CPU]);
endmodule

// File: tb/sim_rst_cause_ctrl.sv
`timescale 1ns/1ps
module sim_rst_cause_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pin_r = 0, wdt_r = 0, bod_r = 0, sys_r = 0, unlock = 0, wr = 0, sel = 0;
  logic [7:0] wdata = '0, rdata;
  logic chip_rst, cpu_rst;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  rst_cause_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_req_i(pin_r), .wdt_req_i(wdt_r),
    .bod_req_i(bod_r), .sys_req_i(sys_r), .unlock_i(unlock), .wr_en_i(wr),
    .reg_sel_i(sel), .wdata_i(wdata), .rdata_o(rdata),
    .chip_rst_o(chip_rst), .cpu_rst_o(cpu_rst)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic rd(logic s, output logic [7:0] v);
    sel = s; #1; v = rdata;
  endtask

  // one write; returns on the falling edge after the write edge
  task automatic bus_wr(logic s, logic [7:0] d);
    @(negedge clk); wr = 1; sel = s; wdata = d;
    @(negedge clk); wr = 0; wdata = '0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(0, v); chk("R1 status", v, 8'h01);
    rd(1, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 outs", {6'b0, cpu_rst, chip_rst}, 8'h00);
  endtask

  task automatic t_sources();
    logic [7:0] v;
    bus_wr(0, 8'hFF); rd(0, v); chk("R2 clear all", v, 8'h00);
    @(negedge clk); pin_r = 1; @(negedge clk); pin_r = 0;
    rd(0, v); chk("R3 pin bit1", v, 8'h02);
    bus_wr(0, 8'h02);
    @(negedge clk); wdt_r = 1; @(negedge clk); wdt_r = 0;
    rd(0, v); chk("R3 wdt bit2", v, 8'h04);
    bus_wr(0, 8'h04);
    @(negedge clk); bod_r = 1; @(negedge clk); bod_r = 0;
    rd(0, v); chk("R3 bod bit4", v, 8'h10);
    bus_wr(0, 8'h10);
    @(negedge clk); sys_r = 1; @(negedge clk); sys_r = 0;
    rd(0, v); chk("R3 sys bit5", v, 8'h20);
    bus_wr(0, 8'h20); rd(0, v); chk("R2 single clear", v, 8'h00);
  endtask

  task automatic t_multi();
    logic [7:0] v;
    @(negedge clk); pin_r = 1; wdt_r = 1; bod_r = 1; sys_r = 1;
    @(negedge clk); pin_r = 0; wdt_r = 0; bod_r = 0; sys_r = 0;
    rd(0, v); chk("R4 all at once", v, 8'h36);
    bus_wr(0, 8'h00); rd(0, v); chk("R2 write zero", v, 8'h36);
    bus_wr(0, 8'h02); rd(0, v); chk("R2 partial clear", v, 8'h34);
    @(negedge clk); wr = 1; sel = 0; wdata = 8'h04; wdt_r = 1;
    @(negedge clk); wr = 0; wdata = '0; wdt_r = 0;
    rd(0, v); chk("R5 set beats clear", v, 8'h34);
    bus_wr(0, 8'h48); rd(0, v); chk("R10 status unused", v, 8'h34);
  endtask

  task automatic t_locked();
    logic [7:0] v;
    unlock = 0;
    bus_wr(1, 8'h03);
    for (int k = 0; k < 3; k++) begin
      rd(1, v); chk("R6 ctrl locked", v, 8'h00);
      chk("R6 outs locked", {6'b0, cpu_rst, chip_rst}, 8'h00);
      @(negedge clk);
    end
    rd(0, v); chk("R6 flags kept", v, 8'h34);
  endtask

  task automatic t_chip();
    logic [7:0] v;
    int hi = 0;
    unlock = 1;
    bus_wr(1, 8'h01);
    rd(1, v); chk("R7 ctrl bit0 set", v, 8'h01);
    chk("R9 cpu idle", {7'b0, cpu_rst}, 8'h00);
    for (int k = 0; k < 4; k++) begin
      if (chip_rst) hi++;
      @(negedge clk);
    end
    chk("R7 pulse width", 8'(hi), 8'd2);
    rd(1, v); chk("R7 self clear", v, 8'h00);
    rd(0, v); chk("R8 por flag, rest kept", v, 8'h35);
  endtask

  task automatic t_cpu();
    logic [7:0] v;
    int hi = 0, chip_hi = 0;
    bus_wr(0, 8'hFF);
    bus_wr(1, 8'h02);
    rd(1, v); chk("R9 ctrl bit1 set", v, 8'h02);
    for (int k = 0; k < 4; k++) begin
      if (cpu_rst) hi++;
      if (chip_rst) chip_hi++;
      @(negedge clk);
    end
    chk("R9 pulse width", 8'(hi), 8'd2);
    chk("R9 chip stays low", 8'(chip_hi), 8'd0);
    rd(0, v); chk("R9 cpu flag", v, 8'h80);
  endtask

  task automatic t_unused_ctrl();
    logic [7:0] v;
    int hi = 0;
    bus_wr(0, 8'hFF);
    bus_wr(1, 8'hFC);
    for (int k = 0; k < 3; k++) begin
      rd(1, v); chk("R10 ctrl unused", v, 8'h00);
      if (chip_rst || cpu_rst) hi++;
      @(negedge clk);
    end
    chk("R10 no pulse", 8'(hi), 8'd0);
    rd(0, v); chk("R10 flags idle", v, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sources();
    t_multi();
    t_locked();
    t_chip();
    t_cpu();
    t_unused_ctrl();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule